// File: doc/BRIEF.md
# Tagged SPI Data-Port Word Packer

This block sits between a 32-bit register bus and the two data FIFOs of an SPI controller. On the transmit side it decodes four write addresses: one takes a full 4-byte word, the other three take words of 1, 2 and 3 bytes. The address that is written sets the byte count. The block stores that count as a 2-bit tag beside the 32-bit data in each FIFO entry, so the downstream shifter sends only the valid bytes. Lanes that are not used in a short word are filled with ones. A short word may only enter an empty transmit FIFO. A short write that arrives while entries are still queued is discarded and sets a sticky error flag.

On the receive side the shifter pushes words together with the same kind of byte-count tag. Its valid bytes sit in the low lanes, in arrival order. A bus read of the receive data address pops one entry and returns it in the next cycle. A partial word is moved up so that its bytes fill the most significant lanes, and the lanes below them read as zero. A read of an empty receive FIFO returns zero and leaves the FIFO as it was.

Top module: `spwp_top`

## Requirements
- R1: A bus write to offset 0x1C queues one transmit entry whose data equals the write data unchanged and whose tag is 0 (tag 0 means four bytes).
- R2: A bus write to offsets 0x80, 0x84 or 0x88 into an empty transmit FIFO queues one entry with tag 1, 2 or 3 respectively. Byte lanes 0 up to tag−1 (lane 0 = bits 7:0) carry the write data, and every higher lane is 0xFF.
- R3: A write to a short-word offset while the transmit FIFO holds any entry is discarded: the queue afterwards holds exactly the entries it held before.
- R4: A discarded short write sets `short_err`. The flag stays set until reset, and nothing else sets it.
- R5: A full-word write while the transmit FIFO is full is discarded without setting `short_err`.
- R6: Transmit entries leave in write order, one per cycle in which `tx_valid` and `tx_ready` are both high. `tx_valid` is low when the FIFO is empty.
- R7: A receive entry pushed with tag n (1..3) holds its bytes in lanes 0..n−1. A read of offset 0x20 returns them in lanes 4−n..3, with the first byte in lane 4−n and the lanes below it zero. Tag 0 returns the word unchanged. `bus_rdata` changes at the clock edge that accepts the read.
- R8: A read of offset 0x20 while the receive FIFO is empty returns zero and pops nothing.
- R9: A receive push while the receive FIFO is full is discarded, and `rx_full` is high exactly when the FIFO holds DEPTH entries.
- R10: After reset, `tx_valid`, `rx_full` and `short_err` are low and `bus_rdata` is zero.
- R11: A read of any other offset returns zero without popping, and a write to any other offset queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| short_err | output | 1 | Sticky flag: a short write was discarded |
| tx_valid | output | 1 | Transmit entry available to the shifter |
| tx_ready | input | 1 | Shifter takes the head transmit entry |
| tx_data | output | 32 | Head transmit data, padded |
| tx_len | output | 2 | Head transmit byte-count tag (0 = four) |
| rx_push | input | 1 | Shifter delivers a received word |
| rx_data | input | 32 | Received bytes, low lanes first |
| rx_len | input | 2 | Received byte-count tag (0 = four) |
| rx_full | output | 1 | Receive FIFO full |

## Verification
The bench builds the block with DEPTH set to 4 for both FIFOs. With that depth, a fifth full-word write and a fifth receive push reach the overflow paths within a few cycles, and the bench can confirm that the dropped word never comes out of either queue. The address offsets keep their defaults, so every short-word address and every unmapped offset is exercised by its literal value.

// File: rtl/spwp_pkg.sv
package spwp_pkg;

  localparam int BYTES = 4;
  localparam int DW    = 8 * BYTES;
  localparam int TAGW  = 2;

  typedef logic [TAGW-1:0] tag_t;

  typedef struct packed {
    logic [DW-1:0] data;
    tag_t          nb;   // 0 = all four bytes, else count of valid bytes
  } entry_t;

  localparam int ENTRY_W = DW + TAGW;

  // Fill every lane at or above the byte count with ones.
  function automatic logic [DW-1:0] pad_ones(input logic [DW-1:0] w, input tag_t nb);
    logic [DW-1:0] r;
    r = w;
    for (int k = 0; k < BYTES; k++) begin
      if (nb != '0 && k >= int'(nb)) r[8*k +: 8] = 8'hFF;
    end
    return r;
  endfunction

  // Move the low nb bytes up into the top lanes, zero below.
  function automatic logic [DW-1:0] align_hi(input logic [DW-1:0] w, input tag_t nb);
    logic [DW-1:0] r;
    case (nb)
      2'd1:    r = w << (8 * (BYTES - 1));
      2'd2:    r = w << (8 * (BYTES - 2));
      2'd3:    r = w << (8 * (BYTES - 3));
      default: r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spwp_fifo.sv
module spwp_fifo #(
  parameter int W     = 34,
  parameter int DEPTH = 16   // power of two, at least 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic          do_push, do_pop;

  assign level   = wr_q - rd_q;
  assign empty   = (wr_q == rd_q);
  assign full    = (level == CW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rd_q[AW-1:0]];

  always_comb begin
    wr_d = wr_q;
    rd_d = rd_q;
    if (do_push) wr_d = wr_q + CW'(1);
    if (do_pop)  rd_d = rd_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q[AW-1:0]] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (level == $past(level))); // R5

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)); // R9

endmodule

// File: rtl/spwp_tx_pack.sv
module spwp_tx_pack
  import spwp_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] OFF_WORD   = 8'h1C,
  parameter logic [ADDR_W-1:0] OFF_SHORT  = 8'h80,
  parameter int                OFF_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  output logic              push,
  output entry_t            entry,
  output logic              short_drop,
  output logic              err
);
  logic [BYTES-1:1] short_hit;
  logic             word_hit, any_short;
  tag_t             short_nb;
  logic             err_q, err_d;

  genvar g;
  generate
    for (g = 1; g < BYTES; g++) begin : g_short
      assign short_hit[g] = (bus_addr == ADDR_W'(OFF_SHORT + (g - 1) * OFF_STRIDE));
    end
  endgenerate

  assign word_hit  = (bus_addr == OFF_WORD);
  assign any_short = |short_hit;

  always_comb begin
    short_nb = '0;
    for (int k = 1; k < BYTES; k++) begin
      if (short_hit[k]) short_nb = tag_t'(k);
    end
  end

  always_comb begin
    push       = 1'b0;
    short_drop = 1'b0;
    entry      = '0;
    if (bus_wr && word_hit) begin
      push       = ~fifo_full;
      entry.data = bus_wdata;
      entry.nb   = '0;
    end else if (bus_wr && any_short) begin
      push       = fifo_empty;
      short_drop = ~fifo_empty;
      entry.data = pad_ones(bus_wdata, short_nb);
      entry.nb   = short_nb;
    end
  end

  assign err_d = err_q | short_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R4

  AST_SHORT_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (push && entry.nb != '0) |-> fifo_empty); // R3

endmodule

// File: rtl/spwp_rx_port.sv
module spwp_rx_port
  import spwp_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_RX = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  entry_t            head,
  input  logic              fifo_empty,
  output logic              pop,
  output logic [DW-1:0]     rdata
);
  logic          rx_hit;
  logic [DW-1:0] rdata_q, rdata_d;

  assign rx_hit = bus_rd && (bus_addr == OFF_RX);
  assign pop    = rx_hit && !fifo_empty;

  always_comb begin
    rdata_d = '0;
    if (pop) rdata_d = align_hi(head.data, head.nb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && fifo_empty) |=> (rdata_q == '0)); // R8

  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rx_hit) |=> (rdata_q == '0)); // R11

endmodule

// File: rtl/spwp_top.sv
module spwp_top
  import spwp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              short_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [31:0]       tx_data,
  output logic [1:0]        tx_len,
  input  logic              rx_push,
  input  logic [31:0]       rx_data,
  input  logic [1:0]        rx_len,
  output logic              rx_full
);
  localparam int LW = $clog2(DEPTH) + 1;

  entry_t         tx_in, tx_head, rx_in, rx_head;
  logic           tx_push, tx_empty, tx_full, short_drop;
  logic           rx_pop, rx_empty;
  logic [LW-1:0]  tx_level, rx_level;

  spwp_tx_pack #(.ADDR_W(ADDR_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .fifo_empty (tx_empty),
    .fifo_full  (tx_full),
    .push       (tx_push),
    .entry      (tx_in),
    .short_drop (short_drop),
    .err        (short_err)
  );

  spwp_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push),
    .pop   (tx_ready),
    .din   (tx_in),
    .dout  (tx_head),
    .empty (tx_empty),
    .full  (tx_full),
    .level (tx_level)
  );

  assign tx_valid = ~tx_empty;
  assign tx_data  = tx_head.data;
  assign tx_len   = tx_head.nb;

  assign rx_in.data = rx_data;
  assign rx_in.nb   = rx_len;

  spwp_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .pop   (rx_pop),
    .din   (rx_in),
    .dout  (rx_head),
    .empty (rx_empty),
    .full  (rx_full),
    .level (rx_level)
  );

  spwp_rx_port #(.ADDR_W(ADDR_W)) u_rport (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .head       (rx_head),
    .fifo_empty (rx_empty),
    .pop        (rx_pop),
    .rdata      (bus_rdata)
  );

  AST_SHORT_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (short_drop && !tx_ready) |=> (tx_level == $past(tx_level))); // R3

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    short_drop |=> short_err); // R4

  AST_RX_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !rx_push) |=> (rx_level == $past(rx_level) - LW'(1))); // R7

  AST_PAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_len == 2'd1) |-> (tx_data[31:8] == 24'hFFFFFF)); // R2

endmodule

// File: tb/sim_spwp_top.sv
module sim_spwp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd, tx_ready, rx_push;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, rx_data, bus_rdata, tx_data;
  logic [1:0]  rx_len, tx_len;
  logic        short_err, tx_valid, rx_full;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spwp_top #(.ADDR_W(8), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .short_err(short_err), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_len(tx_len), .rx_push(rx_push),
    .rx_data(rx_data), .rx_len(rx_len), .rx_full(rx_full)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic rx_send(input logic [31:0] d, input logic [1:0] n);
    @(negedge clk); rx_push = 1; rx_data = d; rx_len = n;
    @(negedge clk); rx_push = 0;
  endtask

  // Check the head transmit entry, then take it.
  task automatic tx_take(input string req, input logic [31:0] d, input logic [1:0] n);
    @(negedge clk);
    check(req, {31'd0, tx_valid}, 32'd1);
    check(req, tx_data, d);
    check(req, {30'd0, tx_len}, {30'd0, n});
    tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic t_reset;
    check("R10 tx_valid", {31'd0, tx_valid}, 0);
    check("R10 rx_full", {31'd0, rx_full}, 0);
    check("R10 short_err", {31'd0, short_err}, 0);
    check("R10 rdata", bus_rdata, 0);
  endtask

  task automatic t_full_words;
    bus_write(8'h1C, 32'hA5A5_1234);
    bus_write(8'h1C, 32'h0BAD_F00D);
    tx_take("R1", 32'hA5A5_1234, 2'd0);
    tx_take("R6 order", 32'h0BAD_F00D, 2'd0);
    @(negedge clk); check("R6 empty", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_short_words;
    bus_write(8'h80, 32'h1122_3344); tx_take("R2 one", 32'hFFFF_FF44, 2'd1);
    bus_write(8'h84, 32'h1122_3344); tx_take("R2 two", 32'hFFFF_3344, 2'd2);
    bus_write(8'h88, 32'h1122_3344); tx_take("R2 three", 32'hFF22_3344, 2'd3);
    check("R4 no err yet", {31'd0, short_err}, 0);
  endtask

  task automatic t_tx_full;
    for (int i = 0; i < 5; i++) bus_write(8'h1C, 32'h100 + i);
    check("R5 no err", {31'd0, short_err}, 0);
    for (int i = 0; i < 4; i++) tx_take("R5 kept", 32'h100 + i, 2'd0);
    @(negedge clk); check("R5 fifth dropped", {31'd0, tx_valid}, 0);
  endtask

  task automatic t_short_blocked;
    bus_write(8'h1C, 32'hCAFE_0001);
    bus_write(8'h84, 32'h5555_6666);
    check("R4 err set", {31'd0, short_err}, 1);
    tx_take("R3 head", 32'hCAFE_0001, 2'd0);
    @(negedge clk); check("R3 dropped", {31'd0, tx_valid}, 0);
    repeat (5) @(negedge clk);
    check("R4 sticky", {31'd0, short_err}, 1);
  endtask

  task automatic t_rx_align;
    logic [31:0] d;
    rx_send(32'h0000_00AA, 2'd1);
    rx_send(32'h0000_BEEF, 2'd2);
    rx_send(32'h0012_3456, 2'd3);
    rx_send(32'h8765_4321, 2'd0);
    bus_read(8'h20, d); check("R7 one", d, 32'hAA00_0000);
    bus_read(8'h20, d); check("R7 two", d, 32'hBEEF_0000);
    bus_read(8'h20, d); check("R7 three", d, 32'h1234_5600);
    bus_read(8'h20, d); check("R7 four", d, 32'h8765_4321);
  endtask

  task automatic t_rx_empty;
    logic [31:0] d;
    bus_read(8'h20, d); check("R8 empty zero", d, 0);
    rx_send(32'h0000_0077, 2'd1);
    bus_read(8'h20, d); check("R8 no pop", d, 32'h7700_0000);
    bus_read(8'h20, d); check("R8 empty again", d, 0);
  endtask

  task automatic t_rx_full;
    logic [31:0] d;
    for (int i = 0; i < 5; i++) rx_send(32'h200 + i, 2'd0);
    check("R9 full", {31'd0, rx_full}, 1);
    for (int i = 0; i < 4; i++) begin
      bus_read(8'h20, d); check("R9 kept", d, 32'h200 + i);
    end
    check("R9 not full", {31'd0, rx_full}, 0);
    bus_read(8'h20, d); check("R9 fifth dropped", d, 0);
  endtask

  task automatic t_other_addr;
    logic [31:0] d;
    rx_send(32'h0000_1234, 2'd2);
    bus_read(8'h24, d); check("R11 other read", d, 0);
    bus_read(8'h20, d); check("R11 not popped", d, 32'h1234_0000);
    bus_write(8'h24, 32'hFFFF_FFFF);
    bus_write(8'h8C, 32'hFFFF_FFFF);
    @(negedge clk); check("R11 no push", {31'd0, tx_valid}, 0);
  endtask

  initial begin
    bus_wr = 0; bus_rd = 0; tx_ready = 0; rx_push = 0;
    bus_addr = '0; bus_wdata = '0; rx_data = '0; rx_len = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_full_words;
    t_short_words;
    t_tx_full;
    t_rx_align;
    t_rx_empty;
    t_rx_full;
    t_other_addr;
    t_short_blocked;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule